// File: doc/BRIEF.md
# Instrumentation Bus Command Decoder with Conditional Q

This block sits behind the slave port of a 24-bit instrumentation crate bus. It decodes the function code presented with each bus strobe and answers with the command-accepted flag (X) and the conditional response flag (Q). It also produces one enable pulse per data command and returns read data. It holds an 8-bit control register and assembles a 24-bit status word. That word is built from the sequencer flags, an external status byte and the control register. The block also drives the module interrupt request (LAM).

The Q response of each data command is gated by the sequencer flags, the block-transfer mode bit and the timeout flag. A command that is refused changes nothing, so the host can simply poll until Q comes back. The FIFOs, the output register and the byte sequencer live outside this block. The block only decides whether a command may proceed and pulses the matching enable.

All responses are combinational within the strobe cycle. Control register updates take effect on the next rising clock edge.

Top module: `bus_cmd_decoder`

## Requirements
- R1: X is 1 only while `strobe_i` is high and `func_i` is one of 0, 1, 4, 6, 9, 16, 17, 20, 22, 24, 26, 28, 30. Any other code, or no strobe, gives X=0 and Q=0 and every enable low.
- R2: Codes 1, 6, 9, 17, 24, 26, 28 and 30 always return Q=1 with X.
- R3: Code 1 returns a status word with the following bit map:
  - bit 23: timeout
  - bit 22: expecting-header
  - bit 21: header-sequence
  - bit 20: write-in-progress
  - bit 19: output-sequence
  - bit 18: write-FIFO not-full
  - bit 17: read-FIFO not-full
  - bit 16: output-ready
  - bits 15..8: external status
  - bits 7..0: `ctrl_o`

  Code 6 returns 0x000050.
- R4: Code 17 loads `wdata_i[3:0]` into control bits 3..0 at the next edge and leaves the other control bits unchanged.
- R5: Codes 24/26 clear/set control bit 5, and codes 28/30 clear/set control bit 6, at the next edge.
- R6: An accepted code 20 loads `wdata_i[23]` into control bit 7. Code 9 clears control bits 7, 6, 5 and 3..0 and pulses `clear_o`. Reset also clears them.
- R7: Control bit 4 always equals `tmo_i`.
- R8: Code 0 gets Q iff output-ready=1, bit 7=0 and timeout=0. Code 4 gets Q iff output-ready=1, bit 7=1 and timeout=0. Either one with Q pulses `or_rd_o` and returns `or_data_i`.
- R9: Code 16 gets Q iff all of the following are 0: timeout, output-ready, output-sequence, bit 7, expecting-header; and the write FIFO is not full. Code 22 uses the same test without bit 7. Q pulses `fifo_wr_o` or `hdr_more_o` respectively.
- R10: Code 20 gets Q iff transfer-pending, timeout and output-ready are all 0. Q pulses `hdr_load_o`.
- R11: Read data is 0 for every command other than code 1, code 6, and code 0 or 4 with Q.
- R12: `lam_o` = timeout OR any external status bit selected by the `LAM_MASK` parameter.
- R13: A command refused with Q=0 changes no control bit and raises no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Bus command strobe, one cycle per command |
| func_i | input | 5 | Function code |
| wdata_i | input | 24 | Bus write data |
| or_data_i | input | 24 | Output register contents |
| tmo_i | input | 1 | Transaction timeout flag |
| exp_hdr_i | input | 1 | Expecting-header flag |
| hdr_seq_i | input | 1 | Header sequence in progress |
| wip_i | input | 1 | Write FIFO drain in progress |
| or_seq_i | input | 1 | Output register load in progress |
| wfifo_nf_i | input | 1 | Write FIFO not full |
| rfifo_nf_i | input | 1 | Read FIFO not full |
| or_rdy_i | input | 1 | Output register ready |
| xfer_pend_i | input | 1 | Transfer pending |
| ext_stat_i | input | 8 | External static status |
| rdata_o | output | 24 | Bus read data |
| x_o | output | 1 | Command accepted |
| q_o | output | 1 | Conditional response |
| or_rd_o | output | 1 | Output register read enable |
| fifo_wr_o | output | 1 | Write FIFO data enable |
| hdr_load_o | output | 1 | Header load and transfer start |
| hdr_more_o | output | 1 | Additional header data enable |
| clear_o | output | 1 | Module clear pulse |
| ctrl_o | output | 8 | Control register |
| lam_o | output | 1 | Module interrupt request |

## Verification
The bench targets the Q gates where one flag decides the outcome:
- Code 0 against code 4 under both block modes. A design with the block-mode test inverted would answer both or neither.
- Code 16 against code 22 with only block mode set. A design that tested block mode on code 22 would lock out header extensions during block reads.
- Refused code 20 commands, whose write data carries the opposite block-mode bit. A design that loaded bit 7 without checking Q would corrupt the mode.
- Unlisted codes and strobe-less cycles. A loose decoder would return X or pulse an enable on them.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int FUNC_W = 5;
  localparam int DATA_W = 24;
  localparam int EXT_W  = 8;
  localparam int CTRL_W = 8;
  localparam int NIB_W  = 4;

  localparam int NCMD      = 13;
  localparam int C_RDOR    = 0;
  localparam int C_STAT    = 1;
  localparam int C_RDBT    = 2;
  localparam int C_ID      = 3;
  localparam int C_CLR     = 4;
  localparam int C_WFIFO   = 5;
  localparam int C_WCTL    = 6;
  localparam int C_HDR     = 7;
  localparam int C_HDRX    = 8;
  localparam int C_ENA_CLR = 9;
  localparam int C_ENA_SET = 10;
  localparam int C_ON_CLR  = 11;
  localparam int C_ON_SET  = 12;

  // control register bit positions
  localparam int B_BT  = 7;
  localparam int B_ON  = 6;
  localparam int B_ENA = 5;
  localparam int B_TMO = 4;

  typedef logic [FUNC_W-1:0] func_t;

  function automatic func_t code_of(int c);
    case (c)
      C_RDOR:    return func_t'(0);
      C_STAT:    return func_t'(1);
      C_RDBT:    return func_t'(4);
      C_ID:      return func_t'(6);
      C_CLR:     return func_t'(9);
      C_WFIFO:   return func_t'(16);
      C_WCTL:    return func_t'(17);
      C_HDR:     return func_t'(20);
      C_HDRX:    return func_t'(22);
      C_ENA_CLR: return func_t'(24);
      C_ENA_SET: return func_t'(26);
      C_ON_CLR:  return func_t'(28);
      default:   return func_t'(30);
    endcase
  endfunction

  // field order equals status word order, msb first
  typedef struct packed {
    logic tmo;
    logic exp_hdr;
    logic hdr_seq;
    logic wip;
    logic or_seq;
    logic wfifo_nf;
    logic rfifo_nf;
    logic or_rdy;
  } seq_flags_t;
endpackage

// File: rtl/bcd_func_dec.sv
module bcd_func_dec
  import bcd_pkg::*;
(
  input  logic             strobe_i,
  input  func_t            func_i,
  output logic [NCMD-1:0]  cmd_o,
  output logic             x_o
);
  for (genvar g = 0; g < NCMD; g++) begin : g_cmd
    localparam func_t CODE = code_of(g);
    assign cmd_o[g] = strobe_i && (func_i == CODE);
  end

  assign x_o = |cmd_o;
endmodule

// File: rtl/bcd_q_gate.sv
module bcd_q_gate
  import bcd_pkg::*;
(
  input  logic [NCMD-1:0] cmd_i,
  input  seq_flags_t      flags_i,
  input  logic            xfer_pend_i,
  input  logic            bt_i,
  output logic [NCMD-1:0] acc_o,
  output logic            q_o
);
  logic [NCMD-1:0] ok;
  logic            wr_ok_nobt;

  // shared write gate; block mode added only for plain FIFO writes
  assign wr_ok_nobt = !flags_i.tmo && !flags_i.or_rdy && !flags_i.or_seq
                      && flags_i.wfifo_nf && !flags_i.exp_hdr;

  always_comb begin
    ok            = '1;
    ok[C_RDOR]    = flags_i.or_rdy && !bt_i && !flags_i.tmo;
    ok[C_RDBT]    = flags_i.or_rdy &&  bt_i && !flags_i.tmo;
    ok[C_WFIFO]   = wr_ok_nobt && !bt_i;
    ok[C_HDRX]    = wr_ok_nobt;
    ok[C_HDR]     = !xfer_pend_i && !flags_i.tmo && !flags_i.or_rdy;
  end

  assign acc_o = cmd_i & ok;
  assign q_o   = |acc_o;
endmodule

// File: rtl/bcd_ctrl_reg.sv
module bcd_ctrl_reg
  import bcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wctl_i,
  input  logic [NIB_W-1:0]  wnib_i,
  input  logic              hdr_i,
  input  logic              bt_val_i,
  input  logic              ena_set_i,
  input  logic              ena_clr_i,
  input  logic              on_set_i,
  input  logic              on_clr_i,
  input  logic              tmo_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic             bt_q, on_q, ena_q;
  logic [NIB_W-1:0] usr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bt_q  <= 1'b0;
      on_q  <= 1'b0;
      ena_q <= 1'b0;
      usr_q <= '0;
    end else if (clr_i) begin
      bt_q  <= 1'b0;
      on_q  <= 1'b0;
      ena_q <= 1'b0;
      usr_q <= '0;
    end else begin
      if (wctl_i)    usr_q <= wnib_i;
      if (hdr_i)     bt_q  <= bt_val_i;
      if (ena_set_i) ena_q <= 1'b1;
      if (ena_clr_i) ena_q <= 1'b0;
      if (on_set_i)  on_q  <= 1'b1;
      if (on_clr_i)  on_q  <= 1'b0;
    end
  end

  assign ctrl_o = {bt_q, on_q, ena_q, tmo_i, usr_q};

  assert_nib_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wctl_i |=> ctrl_o[NIB_W-1:0] == $past(wnib_i));
  assert_nib_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wctl_i && !clr_i) |=> $stable(ctrl_o[NIB_W-1:0]));
  assert_ena_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ena_set_i |=> ctrl_o[B_ENA]);
  assert_on_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_clr_i |=> !ctrl_o[B_ON]);
  assert_bt_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_i |=> ctrl_o[B_BT] == $past(bt_val_i));
  assert_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ctrl_o[B_BT:B_ENA] == '0) && (ctrl_o[NIB_W-1:0] == '0));
  assert_bt_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hdr_i && !clr_i) |=> $stable(ctrl_o[B_BT]));
endmodule

// File: rtl/bcd_rd_mux.sv
module bcd_rd_mux
  import bcd_pkg::*;
#(
  parameter logic [EXT_W-1:0]  LAM_MASK  = 8'h0F,
  parameter logic [DATA_W-1:0] MODULE_ID = 24'h000050
) (
  input  logic [NCMD-1:0]   acc_i,
  input  seq_flags_t        flags_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] or_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lam_o
);
  logic [EXT_W-1:0] lam_terms;

  for (genvar g = 0; g < EXT_W; g++) begin : g_lam
    if (LAM_MASK[g]) begin : g_on
      assign lam_terms[g] = ext_i[g];
    end else begin : g_off
      assign lam_terms[g] = 1'b0;
    end
  end

  assign lam_o = flags_i.tmo || (|lam_terms);

  always_comb begin
    rdata_o = '0;
    if (acc_i[C_STAT])                   rdata_o = {flags_i, ext_i, ctrl_i};
    if (acc_i[C_ID])                     rdata_o = MODULE_ID;
    if (acc_i[C_RDOR] || acc_i[C_RDBT])  rdata_o = or_data_i;
  end
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
  import bcd_pkg::*;
#(
  parameter logic [EXT_W-1:0]  LAM_MASK  = 8'h0F,
  parameter logic [DATA_W-1:0] MODULE_ID = 24'h000050
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] or_data_i,
  input  logic              tmo_i,
  input  logic              exp_hdr_i,
  input  logic              hdr_seq_i,
  input  logic              wip_i,
  input  logic              or_seq_i,
  input  logic              wfifo_nf_i,
  input  logic              rfifo_nf_i,
  input  logic              or_rdy_i,
  input  logic              xfer_pend_i,
  input  logic [EXT_W-1:0]  ext_stat_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              x_o,
  output logic              q_o,
  output logic              or_rd_o,
  output logic              fifo_wr_o,
  output logic              hdr_load_o,
  output logic              hdr_more_o,
  output logic              clear_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              lam_o
);
  logic [NCMD-1:0] cmd, acc;
  seq_flags_t      flags;

  assign flags = '{tmo: tmo_i, exp_hdr: exp_hdr_i, hdr_seq: hdr_seq_i,
                   wip: wip_i, or_seq: or_seq_i, wfifo_nf: wfifo_nf_i,
                   rfifo_nf: rfifo_nf_i, or_rdy: or_rdy_i};

  bcd_func_dec u_dec (
    .strobe_i (strobe_i),
    .func_i   (func_i),
    .cmd_o    (cmd),
    .x_o      (x_o)
  );

  bcd_q_gate u_qg (
    .cmd_i       (cmd),
    .flags_i     (flags),
    .xfer_pend_i (xfer_pend_i),
    .bt_i        (ctrl_o[B_BT]),
    .acc_o       (acc),
    .q_o         (q_o)
  );

  bcd_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (acc[C_CLR]),
    .wctl_i    (acc[C_WCTL]),
    .wnib_i    (wdata_i[NIB_W-1:0]),
    .hdr_i     (acc[C_HDR]),
    .bt_val_i  (wdata_i[DATA_W-1]),
    .ena_set_i (acc[C_ENA_SET]),
    .ena_clr_i (acc[C_ENA_CLR]),
    .on_set_i  (acc[C_ON_SET]),
    .on_clr_i  (acc[C_ON_CLR]),
    .tmo_i     (tmo_i),
    .ctrl_o    (ctrl_o)
  );

  bcd_rd_mux #(.LAM_MASK(LAM_MASK), .MODULE_ID(MODULE_ID)) u_rd (
    .acc_i     (acc),
    .flags_i   (flags),
    .ext_i     (ext_stat_i),
    .ctrl_i    (ctrl_o),
    .or_data_i (or_data_i),
    .rdata_o   (rdata_o),
    .lam_o     (lam_o)
  );

  assign or_rd_o    = acc[C_RDOR] || acc[C_RDBT];
  assign fifo_wr_o  = acc[C_WFIFO];
  assign hdr_load_o = acc[C_HDR];
  assign hdr_more_o = acc[C_HDRX];
  assign clear_o    = acc[C_CLR];

  assert_one_cmd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd));
  assert_x_needs_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_o |-> strobe_i);
  assert_q_needs_x_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o |-> x_o);
  assert_stat_q_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && func_i == FUNC_W'(1)) |-> q_o);
  assert_rdor_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && func_i == FUNC_W'(0)) |-> (or_rdy_i && !ctrl_o[B_BT] && !tmo_i));
  assert_rdbt_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && func_i == FUNC_W'(4)) |-> (or_rdy_i && ctrl_o[B_BT] && !tmo_i));
  assert_wfifo_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> (!tmo_i && !or_rdy_i && !or_seq_i && !ctrl_o[B_BT]
                   && wfifo_nf_i && !exp_hdr_i));
  assert_hdr_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_load_o |-> (!xfer_pend_i && !tmo_i && !or_rdy_i));
  assert_lam_tmo_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |-> lam_o);
  assert_refused_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_o |-> !(or_rd_o || fifo_wr_o || hdr_load_o || hdr_more_o || clear_o));
endmodule

// File: tb/bus_cmd_decoder_tb.sv
module bus_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LAM_MASK = 8'h0F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [4:0]  func_i = '0;
  logic [23:0] wdata_i = '0, or_data_i = '0;
  logic tmo_i = 0, exp_hdr_i = 0, hdr_seq_i = 0, wip_i = 0, or_seq_i = 0;
  logic wfifo_nf_i = 0, rfifo_nf_i = 0, or_rdy_i = 0, xfer_pend_i = 0;
  logic [7:0]  ext_stat_i = '0;
  logic [23:0] rdata_o;
  logic x_o, q_o, or_rd_o, fifo_wr_o, hdr_load_o, hdr_more_o, clear_o, lam_o;
  logic [7:0]  ctrl_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state: stored control bits (bit 4 is not stored)
  logic [7:0] m_ctrl = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_cmd_decoder #(.LAM_MASK(LAM_MASK)) u_dut (
    .clk_i, .rst_ni, .strobe_i, .func_i, .wdata_i, .or_data_i, .tmo_i,
    .exp_hdr_i, .hdr_seq_i, .wip_i, .or_seq_i, .wfifo_nf_i, .rfifo_nf_i,
    .or_rdy_i, .xfer_pend_i, .ext_stat_i, .rdata_o, .x_o, .q_o, .or_rd_o,
    .fifo_wr_o, .hdr_load_o, .hdr_more_o, .clear_o, .ctrl_o, .lam_o
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h (func=%0d t=%0t)",
               req, what, got, exp, func_i, $time);
    end
  endtask

  function automatic bit listed(int f);
    return f inside {0, 1, 4, 6, 9, 16, 17, 20, 22, 24, 26, 28, 30};
  endfunction

  // compare all outputs against model for current inputs, then advance model
  task automatic step();
    int  f;
    bit  x, q, bt, wok;
    logic [23:0] rd;
    logic [7:0]  ctl;
    string qreq;
    #1;
    f   = int'(func_i);
    bt  = m_ctrl[7];
    ctl = {m_ctrl[7:5], tmo_i, m_ctrl[3:0]};
    x   = strobe_i && listed(f);
    wok = !tmo_i && !or_rdy_i && !or_seq_i && wfifo_nf_i && !exp_hdr_i;
    q   = 0;
    qreq = "R2";
    case (f)
      0:  begin q = or_rdy_i && !bt && !tmo_i; qreq = "R8";  end
      4:  begin q = or_rdy_i &&  bt && !tmo_i; qreq = "R8";  end
      16: begin q = wok && !bt;                qreq = "R9";  end
      22: begin q = wok;                       qreq = "R9";  end
      20: begin q = !xfer_pend_i && !tmo_i && !or_rdy_i; qreq = "R10"; end
      default: q = 1;
    endcase
    q = q && x;
    if (!x) qreq = "R1";
    rd = '0;
    if (x && f == 1) rd = {tmo_i, exp_hdr_i, hdr_seq_i, wip_i, or_seq_i,
                           wfifo_nf_i, rfifo_nf_i, or_rdy_i, ext_stat_i, ctl};
    if (x && f == 6) rd = 24'h000050;
    if (q && (f == 0 || f == 4)) rd = or_data_i;

    chk("R1", "x", x_o, x);
    chk(qreq, "q", q_o, q);
    chk((f == 1 || f == 6) ? "R3" : "R11", "rdata", rdata_o, rd);
    chk("R7", "ctrl", ctrl_o, ctl);
    chk("R8", "or_rd", or_rd_o, q && (f == 0 || f == 4));
    chk("R9", "fifo_wr", fifo_wr_o, q && f == 16);
    chk("R9", "hdr_more", hdr_more_o, q && f == 22);
    chk("R10", "hdr_load", hdr_load_o, q && f == 20);
    chk("R6", "clear", clear_o, q && f == 9);
    chk("R12", "lam", lam_o, tmo_i || |(ext_stat_i & LAM_MASK));

    if (q) begin
      case (f)
        9:  m_ctrl = '0;
        17: m_ctrl[3:0] = wdata_i[3:0];
        20: m_ctrl[7] = wdata_i[23];
        24: m_ctrl[5] = 0;
        26: m_ctrl[5] = 1;
        28: m_ctrl[6] = 0;
        30: m_ctrl[6] = 1;
        default: ;
      endcase
    end
    @(negedge clk_i);
  endtask

  // flags: {pend, tmo, exph, hseq, wip, orseq, wnf, rnf, ordy}
  task automatic cmd(input int f, input logic [23:0] wd, input logic [8:0] fl);
    strobe_i = 1;
    func_i   = 5'(f);
    wdata_i  = wd;
    {xfer_pend_i, tmo_i, exp_hdr_i, hdr_seq_i, wip_i, or_seq_i,
     wfifo_nf_i, rfifo_nf_i, or_rdy_i} = fl;
    step();
  endtask

  localparam logic [8:0] IDLE  = 9'b0_0000_0110; // fifos not full, nothing busy
  localparam logic [8:0] ORDY  = 9'b0_0000_0111;
  localparam logic [8:0] TMO   = 9'b0_1000_0110;
  localparam logic [8:0] PEND  = 9'b1_0000_0110;
  localparam logic [8:0] EXPH  = 9'b0_0100_0110;
  localparam logic [8:0] WFULL = 9'b0_0000_0010;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    or_data_i  = 24'hA5C3E1;
    ext_stat_i = 8'h00;
    repeat (3) @(negedge clk_i);
    // reset state
    chk("R6", "reset ctrl", ctrl_o, 8'h00);
    chk("R1", "reset x", x_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R5 mode bits, R4 nibble
    cmd(26, 24'h0, IDLE);
    cmd(30, 24'h0, IDLE);
    cmd(17, 24'hFFFFF9, IDLE);
    cmd(1, 24'h0, IDLE);            // R3 status with ctrl 0x69
    cmd(6, 24'h0, TMO);             // R3 id, R2 always Q
    cmd(24, 24'h0, IDLE);
    cmd(28, 24'h0, IDLE);
    // R6 block mode via code 20, then refused code 20 (R13)
    cmd(20, 24'h800000, IDLE);
    cmd(20, 24'h000000, TMO);
    cmd(20, 24'h000000, PEND);
    cmd(20, 24'h000000, ORDY);
    cmd(1, 24'h0, IDLE);
    // R8 read gates in block mode
    cmd(0, 24'h0, ORDY);
    cmd(4, 24'h0, ORDY);
    cmd(4, 24'h0, ORDY | TMO);
    // R9 code 16 vs 22 under block mode
    cmd(16, 24'h0, IDLE);
    cmd(22, 24'h0, IDLE);
    cmd(22, 24'h0, EXPH);
    cmd(22, 24'h0, WFULL);
    // leave block mode
    cmd(20, 24'h000000, IDLE);
    cmd(0, 24'h0, ORDY);
    cmd(4, 24'h0, ORDY);
    cmd(16, 24'h0, IDLE);
    cmd(16, 24'h0, ORDY);
    // R1 unlisted codes and no strobe
    cmd(2, 24'h0, IDLE);
    cmd(31, 24'h0, IDLE);
    strobe_i = 0; func_i = 5'd26; step();
    // R12 lam mask
    strobe_i = 0; ext_stat_i = 8'hF0; step();
    ext_stat_i = 8'h04; step();
    ext_stat_i = 8'h00;
    // R6 clear
    cmd(30, 24'h0, IDLE);
    cmd(20, 24'h800000, IDLE);
    cmd(9, 24'h0, IDLE);
    cmd(1, 24'h0, IDLE);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int pick;
      logic [8:0] fl;
      pick = $urandom_range(0, 15);
      case (pick)
        0: func_i = 5'd0;   1: func_i = 5'd1;   2: func_i = 5'd4;
        3: func_i = 5'd6;   4: func_i = 5'd9;   5: func_i = 5'd16;
        6: func_i = 5'd17;  7: func_i = 5'd20;  8: func_i = 5'd22;
        9: func_i = 5'd24;  10: func_i = 5'd26; 11: func_i = 5'd28;
        12: func_i = 5'd30; default: func_i = 5'($urandom_range(0, 31));
      endcase
      fl = 9'($urandom) & 9'($urandom) | 9'b0_0000_0110;
      if ($urandom_range(0, 3) == 0) fl[0] = 1;
      if ($urandom_range(0, 5) == 0) fl[2] = 0;
      strobe_i = ($urandom_range(0, 7) != 0);
      wdata_i  = 24'($urandom);
      or_data_i = 24'($urandom);
      ext_stat_i = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      {xfer_pend_i, tmo_i, exp_hdr_i, hdr_seq_i, wip_i, or_seq_i,
       wfifo_nf_i, rfifo_nf_i, or_rdy_i} = fl;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule